// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits beside an instruction pipeline and decides how control passes into and out of interrupt handlers. A hardware request stores the interrupted instruction pointer and the current privilege mask in two dedicated shadow registers. It then raises the privilege mask to all ones, looks up the handler in a one-word-per-vector table and redirects fetch there. Until the matching hardware return, it accepts no further hardware request. A software interrupt does not use the shadow registers. It emits a write of the current privilege mask and the next-instruction address into general registers 0 and 1. It then raises the mask to all ones and reads the handler address from a two-word-per-vector table.

The two return operations restore the mask and redirect in the cycle they are issued. The hardware return takes both values from the shadow registers. The software return takes them from general registers 0 and 1, which arrive as inputs. The table memory is external and has one cycle of read latency, so each interrupt entry takes two cycles: one to issue the read and one to redirect. The sequencer has three states: `ST_IDLE`, `ST_HW_FETCH` and `ST_SW_FETCH`. In `ST_IDLE`, a software interrupt leads to `ST_SW_FETCH` and an accepted hardware request leads to `ST_HW_FETCH`. A return or an illegal return keeps the sequencer in `ST_IDLE`. Both fetch states go back to `ST_IDLE` after exactly one cycle.

Top module: `intr_seq`

## Requirements
- R1: After reset the privilege mask is all ones, `hw_active` is 0, both shadow registers are 0, and `redirect`, `tbl_rd`, `gpr_wr`, `hw_ack` and `fault` are low.
- R2: In `ST_IDLE`, with `hw_active` low and no higher-priority strobe, `hw_req` is taken. In that cycle `hw_ack` and `tbl_rd` pulse and `tbl_addr` = `HW_BASE + hw_vec`. At the next edge `old_ip` takes `cur_ip`, `old_priv` takes the privilege mask, `hw_active` becomes 1 and the mask becomes all ones.
- R3: In `ST_IDLE`, `sw_strobe` pulses `gpr_wr` with `gpr0_wdata` = the current mask and `gpr1_wdata` = `next_ip`. It also pulses `tbl_rd` with `tbl_addr` = `SW_BASE + 2*sw_vec + 1`, which is the handler word; the privilege word at the even address below it is not read. At the next edge the mask becomes all ones.
- R4: The cycle after any `tbl_rd`, `redirect` is high for that one cycle with `redirect_addr` equal to `tbl_data`.
- R5: While `hw_active` is 1, `hw_req` is never acknowledged and changes no state.
- R6: In `ST_IDLE` with `hw_active` 1, `hw_ret` redirects in the same cycle to `old_ip`. At the next edge the mask takes `old_priv` and `hw_active` clears.
- R7: In `ST_IDLE`, `sw_ret` redirects in the same cycle to `gpr1_in`, and at the next edge the mask takes `gpr0_in`.
- R8: `hw_ret` with `hw_active` 0 raises `fault` for that cycle only, gives no redirect and changes neither the mask, the shadow registers nor `hw_active`.
- R9: When several strobes coincide in `ST_IDLE`, the priority is `sw_strobe`, then `sw_ret`, then `hw_ret`, then `hw_req`. A request that loses stays pending, and a held `hw_req` is taken in the next eligible idle cycle.
- R10: Strobes that arrive during a fetch cycle are ignored: they produce no acknowledge, no register write, no fault and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_req | input | 1 | Hardware interrupt request, held until acknowledged |
| hw_vec | input | VEC_W | Hardware vector index |
| hw_ack | output | 1 | Hardware request accepted this cycle |
| sw_strobe | input | 1 | Software interrupt instruction |
| sw_vec | input | VEC_W | Software vector index |
| sw_ret | input | 1 | Software return instruction |
| hw_ret | input | 1 | Hardware return instruction |
| cur_ip | input | W | Address of the interrupted instruction |
| next_ip | input | W | Address of the instruction after the current one |
| gpr0_in | input | W | Value of general register 0 |
| gpr1_in | input | W | Value of general register 1 |
| tbl_rd | output | 1 | Table read request |
| tbl_addr | output | AW | Table word address |
| tbl_data | input | W | Table read data, one cycle after `tbl_rd` |
| redirect | output | 1 | Fetch redirect strobe |
| redirect_addr | output | W | Redirect target |
| priv | output | W | Privilege mask |
| old_priv | output | W | Shadow copy of the mask |
| old_ip | output | W | Shadow copy of the instruction pointer |
| hw_active | output | 1 | Hardware handler running |
| gpr_wr | output | 1 | Write general registers 0 and 1 |
| gpr0_wdata | output | W | Data for general register 0 |
| gpr1_wdata | output | W | Data for general register 1 |
| fault | output | 1 | Hardware return with no handler active |

## Verification
Every register in this block is visible at the ports: the mask, both shadow copies and `hw_active`. A wrong save or restore therefore shows at the edge that follows the entry or return. The reference model compares all of them in every cycle. A wrong state transition shows one cycle later, either as a missing or extra `redirect` or as a strobe that is acknowledged during a fetch cycle. A wrong priority decision shows in the same cycle on `hw_ack`, `gpr_wr` or `fault`. A table address built from the wrong base or stride shows on `tbl_addr` in the same cycle, and it also shows as a wrong `redirect_addr` in the next cycle, because the bench's memory model returns data that depends on the address.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_HW_FETCH = 2'd1,
        ST_SW_FETCH = 2'd2
    } seq_state_t;
endpackage

// File: rtl/intr_seq_fsm.sv
module intr_seq_fsm
    import intr_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_strobe,
    input  logic       sw_ret,
    input  logic       hw_ret,
    input  logic       hw_req,
    input  logic       hw_active,
    output seq_state_t state,
    output logic       take_sw,
    output logic       take_hw,
    output logic       do_sw_ret,
    output logic       do_hw_ret,
    output logic       bad_hw_ret,
    output logic       fetch_done
);
    seq_state_t state_nx;
    logic       idle;
    logic       hw_ret_sel;

    always_comb begin
        idle       = (state == ST_IDLE);
        take_sw    = idle && sw_strobe;
        do_sw_ret  = idle && !sw_strobe && sw_ret;
        hw_ret_sel = idle && !sw_strobe && !sw_ret && hw_ret;
        do_hw_ret  = hw_ret_sel && hw_active;
        bad_hw_ret = hw_ret_sel && !hw_active;
        take_hw    = idle && !sw_strobe && !sw_ret && !hw_ret && hw_req && !hw_active;
        fetch_done = !idle;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (take_sw)      state_nx = ST_SW_FETCH;
                else if (take_hw) state_nx = ST_HW_FETCH;
            end
            ST_HW_FETCH: state_nx = ST_IDLE;
            ST_SW_FETCH: state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end
endmodule

// File: rtl/intr_seq_ctx.sv
module intr_seq_ctx #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         take_hw,
    input  logic         take_sw,
    input  logic         do_hw_ret,
    input  logic         do_sw_ret,
    input  logic [W-1:0] cur_ip,
    input  logic [W-1:0] gpr0_in,
    output logic [W-1:0] priv,
    output logic [W-1:0] old_priv,
    output logic [W-1:0] old_ip,
    output logic         hw_active
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            priv      <= ALL_ONES;
            old_priv  <= '0;
            old_ip    <= '0;
            hw_active <= 1'b0;
        end else begin
            if (take_hw) begin
                old_priv  <= priv;
                old_ip    <= cur_ip;
                hw_active <= 1'b1;
            end else if (do_hw_ret) begin
                hw_active <= 1'b0;
            end
            if (take_hw || take_sw) priv <= ALL_ONES;
            else if (do_hw_ret)     priv <= old_priv;
            else if (do_sw_ret)     priv <= gpr0_in;
        end
    end
endmodule

// File: rtl/intr_seq_addr.sv
module intr_seq_addr #(
    parameter int            VEC_W   = 4,
    parameter int            AW      = 16,
    parameter logic [AW-1:0] HW_BASE = '0,
    parameter logic [AW-1:0] SW_BASE = '0
) (
    input  logic             use_sw,
    input  logic [VEC_W-1:0] hw_vec,
    input  logic [VEC_W-1:0] sw_vec,
    output logic [AW-1:0]    tbl_addr
);
    localparam int OFF_W = VEC_W + 1;

    logic [OFF_W-1:0] sw_off;
    logic [AW-1:0]    hw_addr;
    logic [AW-1:0]    sw_addr;

    always_comb begin
        sw_off   = {sw_vec, 1'b1};
        hw_addr  = HW_BASE + AW'(hw_vec);
        sw_addr  = SW_BASE + AW'(sw_off);
        tbl_addr = use_sw ? sw_addr : hw_addr;
    end
endmodule

// File: rtl/intr_seq.sv
module intr_seq
    import intr_seq_pkg::*;
#(
    parameter int            W       = 32,
    parameter int            VEC_W   = 4,
    parameter int            AW      = 16,
    parameter logic [AW-1:0] HW_BASE = 16'h0100,
    parameter logic [AW-1:0] SW_BASE = 16'h0200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_req,
    input  logic [VEC_W-1:0] hw_vec,
    output logic             hw_ack,
    input  logic             sw_strobe,
    input  logic [VEC_W-1:0] sw_vec,
    input  logic             sw_ret,
    input  logic             hw_ret,
    input  logic [W-1:0]     cur_ip,
    input  logic [W-1:0]     next_ip,
    input  logic [W-1:0]     gpr0_in,
    input  logic [W-1:0]     gpr1_in,
    output logic             tbl_rd,
    output logic [AW-1:0]    tbl_addr,
    input  logic [W-1:0]     tbl_data,
    output logic             redirect,
    output logic [W-1:0]     redirect_addr,
    output logic [W-1:0]     priv,
    output logic [W-1:0]     old_priv,
    output logic [W-1:0]     old_ip,
    output logic             hw_active,
    output logic             gpr_wr,
    output logic [W-1:0]     gpr0_wdata,
    output logic [W-1:0]     gpr1_wdata,
    output logic             fault
);
    seq_state_t state;
    logic take_sw, take_hw, do_sw_ret, do_hw_ret, bad_hw_ret, fetch_done;

    intr_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .sw_strobe(sw_strobe), .sw_ret(sw_ret), .hw_ret(hw_ret), .hw_req(hw_req),
        .hw_active(hw_active), .state(state),
        .take_sw(take_sw), .take_hw(take_hw), .do_sw_ret(do_sw_ret),
        .do_hw_ret(do_hw_ret), .bad_hw_ret(bad_hw_ret), .fetch_done(fetch_done)
    );

    intr_seq_ctx #(.W(W)) u_ctx (
        .clk(clk), .rst_n(rst_n),
        .take_hw(take_hw), .take_sw(take_sw),
        .do_hw_ret(do_hw_ret), .do_sw_ret(do_sw_ret),
        .cur_ip(cur_ip), .gpr0_in(gpr0_in),
        .priv(priv), .old_priv(old_priv), .old_ip(old_ip), .hw_active(hw_active)
    );

    intr_seq_addr #(.VEC_W(VEC_W), .AW(AW), .HW_BASE(HW_BASE), .SW_BASE(SW_BASE)) u_addr (
        .use_sw(take_sw), .hw_vec(hw_vec), .sw_vec(sw_vec), .tbl_addr(tbl_addr)
    );

    always_comb begin
        tbl_rd     = take_sw || take_hw;
        hw_ack     = take_hw;
        gpr_wr     = take_sw;
        gpr0_wdata = priv;
        gpr1_wdata = next_ip;
        fault      = bad_hw_ret;
        redirect   = fetch_done || do_sw_ret || do_hw_ret;
        if (fetch_done)     redirect_addr = tbl_data;
        else if (do_hw_ret) redirect_addr = old_ip;
        else if (do_sw_ret) redirect_addr = gpr1_in;
        else                redirect_addr = '0;
    end
endmodule

// File: rtl/intr_seq_chk.sv
module intr_seq_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         hw_ack,
    input logic         tbl_rd,
    input logic         redirect,
    input logic         gpr_wr,
    input logic         fault,
    input logic         hw_active,
    input logic [W-1:0] cur_ip,
    input logic [W-1:0] priv,
    input logic [W-1:0] old_priv,
    input logic [W-1:0] old_ip
);
    a_r2_hw_saves: assert property (@(posedge clk) disable iff (!rst_n)
        hw_ack |=> (old_ip == $past(cur_ip)) && (old_priv == $past(priv))
                   && hw_active && (priv == {W{1'b1}}));

    a_r3_sw_raises: assert property (@(posedge clk) disable iff (!rst_n)
        gpr_wr |=> (priv == {W{1'b1}}));

    a_r4_redirect_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_rd |=> redirect);

    a_r5_no_nesting: assert property (@(posedge clk) disable iff (!rst_n)
        hw_active |-> !hw_ack);

    a_r8_fault_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> $stable(priv) && $stable(hw_active) && $stable(old_ip) && $stable(old_priv));

    a_r8_fault_no_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !redirect);

    a_r9_sw_over_hw: assert property (@(posedge clk) disable iff (!rst_n)
        gpr_wr |-> !hw_ack);

    a_r10_fetch_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_rd |=> !tbl_rd && !fault);
endmodule

bind intr_seq intr_seq_chk #(.W(W)) i_chk (
    .clk(clk), .rst_n(rst_n), .hw_ack(hw_ack), .tbl_rd(tbl_rd), .redirect(redirect),
    .gpr_wr(gpr_wr), .fault(fault), .hw_active(hw_active), .cur_ip(cur_ip),
    .priv(priv), .old_priv(old_priv), .old_ip(old_ip)
);

// File: tb/test_intr_seq.sv
module test_intr_seq;
    localparam int CLK_PERIOD = 10;
    localparam int W = 32;
    localparam int VEC_W = 4;
    localparam int AW = 16;
    localparam logic [AW-1:0] HW_BASE = 16'h0100;
    localparam logic [AW-1:0] SW_BASE = 16'h0200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hw_req = 0, sw_strobe = 0, sw_ret = 0, hw_ret = 0;
    logic [VEC_W-1:0] hw_vec = '0, sw_vec = '0;
    logic [W-1:0] cur_ip = '0, next_ip = '0, gpr0_in = '0, gpr1_in = '0;
    logic [W-1:0] tbl_data = '0;
    logic hw_ack, tbl_rd, redirect, hw_active, gpr_wr, fault;
    logic [AW-1:0] tbl_addr;
    logic [W-1:0] redirect_addr, priv, old_priv, old_ip, gpr0_wdata, gpr1_wdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    logic [W-1:0]  m_priv = '1, m_oldp = '0, m_oldip = '0;
    bit            m_active = 0;
    bit            m_fetch = 0;
    logic [AW-1:0] m_faddr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    intr_seq #(.W(W), .VEC_W(VEC_W), .AW(AW), .HW_BASE(HW_BASE), .SW_BASE(SW_BASE)) i_intr_seq (
        .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .hw_vec(hw_vec), .hw_ack(hw_ack),
        .sw_strobe(sw_strobe), .sw_vec(sw_vec), .sw_ret(sw_ret), .hw_ret(hw_ret),
        .cur_ip(cur_ip), .next_ip(next_ip), .gpr0_in(gpr0_in), .gpr1_in(gpr1_in),
        .tbl_rd(tbl_rd), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
        .redirect(redirect), .redirect_addr(redirect_addr), .priv(priv),
        .old_priv(old_priv), .old_ip(old_ip), .hw_active(hw_active),
        .gpr_wr(gpr_wr), .gpr0_wdata(gpr0_wdata), .gpr1_wdata(gpr1_wdata), .fault(fault)
    );

    function automatic logic [W-1:0] mem_word(input logic [AW-1:0] a);
        return {a, ~a} ^ 32'h5A5A_0000;
    endfunction

    // table memory with one cycle of read latency
    always_ff @(posedge clk) if (tbl_rd) tbl_data <= mem_word(tbl_addr);

    task automatic chk(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(input string tag, input bit i_sw, input bit i_swr, input bit i_hwr, input bit i_hreq,
                        input logic [VEC_W-1:0] sv, input logic [VEC_W-1:0] hv,
                        input logic [W-1:0] cip, input logic [W-1:0] nip,
                        input logic [W-1:0] g0, input logic [W-1:0] g1);
        bit e_rd = 0, e_redir = 0, e_gwr = 0, e_ack = 0, e_fault = 0;
        logic [AW-1:0] e_addr = '0;
        logic [W-1:0]  e_raddr = '0;
        sw_strobe = i_sw; sw_ret = i_swr; hw_ret = i_hwr; hw_req = i_hreq;
        sw_vec = sv; hw_vec = hv; cur_ip = cip; next_ip = nip; gpr0_in = g0; gpr1_in = g1;
        #1;
        if (m_fetch) begin
            e_redir = 1; e_raddr = mem_word(m_faddr);
        end else if (i_sw) begin
            e_gwr = 1; e_rd = 1; e_addr = SW_BASE + AW'(2 * int'(sv) + 1);
        end else if (i_swr) begin
            e_redir = 1; e_raddr = g1;
        end else if (i_hwr) begin
            if (m_active) begin e_redir = 1; e_raddr = m_oldip; end
            else e_fault = 1;
        end else if (i_hreq && !m_active) begin
            e_ack = 1; e_rd = 1; e_addr = HW_BASE + AW'(hv);
        end
        chk(tag, "redirect", W'(redirect), W'(e_redir));
        if (e_redir) chk(tag, "redirect_addr", redirect_addr, e_raddr);
        chk(tag, "tbl_rd", W'(tbl_rd), W'(e_rd));
        if (e_rd) chk(tag, "tbl_addr", W'(tbl_addr), W'(e_addr));
        chk(tag, "gpr_wr", W'(gpr_wr), W'(e_gwr));
        if (e_gwr) begin
            chk(tag, "gpr0_wdata", gpr0_wdata, m_priv);
            chk(tag, "gpr1_wdata", gpr1_wdata, nip);
        end
        chk(tag, "hw_ack", W'(hw_ack), W'(e_ack));
        chk(tag, "fault", W'(fault), W'(e_fault));
        chk(tag, "priv", priv, m_priv);
        chk(tag, "old_priv", old_priv, m_oldp);
        chk(tag, "old_ip", old_ip, m_oldip);
        chk(tag, "hw_active", W'(hw_active), W'(m_active));
        @(posedge clk);
        if (m_fetch) begin
            m_fetch = 0;
        end else if (e_gwr) begin
            m_priv = '1; m_fetch = 1; m_faddr = e_addr;
        end else if (i_swr) begin
            m_priv = g0;
        end else if (i_hwr) begin
            if (m_active) begin m_priv = m_oldp; m_active = 0; end
        end else if (e_ack) begin
            m_oldp = m_priv; m_oldip = cip; m_priv = '1; m_active = 1;
            m_fetch = 1; m_faddr = e_addr;
        end
        @(negedge clk);
    endtask

    task automatic quiet(input string tag);
        step(tag, 0, 0, 0, 0, '0, '0, '0, '0, '0, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        quiet("R1");
        // R7: software return lowers the mask
        step("R7", 0, 1, 0, 0, 0, 0, 0, 0, 32'h0000_00F0, 32'h0000_1000);
        // R3, R4: software interrupt and its redirect
        step("R3", 1, 0, 0, 0, 4'd5, 0, 32'h2000, 32'h2004, 0, 0);
        quiet("R4");
        step("R7", 0, 1, 0, 0, 0, 0, 0, 0, 32'h0000_000F, 32'h0000_2004);
        // R2, R4: hardware interrupt
        step("R2", 0, 0, 0, 1, 0, 4'd3, 32'h3000, 32'h3004, 0, 0);
        quiet("R4");
        // R5: held request while a handler runs
        for (int i = 0; i < 3; i++) step("R5", 0, 0, 0, 1, 0, 4'd7, 32'h4000 + W'(i), 0, 0, 0);
        // R6: hardware return
        step("R6", 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
        // R8: return with nothing active
        step("R8", 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
        quiet("R8");
        // R9: software interrupt beats hardware request; request stays pending
        step("R9", 1, 0, 0, 1, 4'd2, 4'd9, 32'h5000, 32'h5004, 0, 0);
        step("R9", 0, 0, 0, 1, 0, 4'd9, 32'h5100, 0, 0, 0);
        step("R9", 0, 0, 0, 1, 0, 4'd9, 32'h5200, 0, 0, 0);
        // R10: strobes during the fetch cycle
        step("R10", 1, 1, 1, 1, 4'd1, 4'd1, 32'h6000, 32'h6004, 32'h11, 32'h22);
        // R9: software return beats hardware return
        step("R9", 0, 1, 1, 0, 0, 0, 0, 0, 32'h0000_0303, 32'h0000_7000);
        step("R6", 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
        // R9: hardware return beats a new request in the same cycle
        step("R9", 0, 0, 1, 1, 0, 4'd4, 32'h7100, 0, 0, 0);
        step("R2", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        step("R7", 0, 1, 0, 0, 0, 0, 0, 0, 32'h0000_0055, 32'h0000_7200);
        // sweep of all vectors in both tables
        for (int v = 0; v < 16; v++) begin
            step("R3", 1, 0, 0, 0, VEC_W'(v), 0, 32'h8000, 32'h8000 + W'(4 * v), 0, 0);
            step("R4", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
            step("R2", 0, 0, 0, 1, 0, VEC_W'(15 - v), 32'h9000 + W'(v), 0, 0, 0);
            step("R4", 0, 0, 0, 1, 0, VEC_W'(15 - v), 0, 0, 0, 0);
            step("R6", 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
            step("R7", 0, 1, 0, 0, 0, 0, 0, 0, W'(v + 1), 32'hA000 + W'(v));
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule